// File: doc/BRIEF.md
# Monitor Entry Key Gate

This block decides whether a debug host may read and execute from protected memory once the chip has reset. After a power-on reset it waits for the reference clock to settle. It then takes eight bytes from the host, one at a time, and compares them with an eight-byte reference key supplied on a parallel input. Every byte it accepts is sent back to the host as an echo after a fixed delay. The host sends its next byte only after it has seen that echo. When the eighth byte has been echoed, the block raises a one-cycle completion pulse. If all eight bytes matched, it sets an unlock flag that stays set.

The unlock flag has its own reset domain, driven only by the power-on reset. An ordinary reset restarts the counters and the sequencer but leaves the flag as it was. An ordinary reset also cancels key entry: until the next power-on reset, host bytes are never echoed or compared. A mismatch does not end reception early. The block still takes and echoes all eight bytes and only then reports the outcome. Bit timing and serial framing are handled outside, as are the receiver, the transmitter and the storage of the key.

Top module: `monitor_key_gate`

## Requirements
- R1: While `por_n` is low, `unlocked`, `echo_valid` and `done_pulse` are all 0.
- R2: After `por_n` rises, strobes on `rx_valid` are ignored (no echo, no comparison) for `SETTLE_CYCLES` reference-clock cycles (default 4128).
- R3: An accepted byte produces a single-cycle `echo_valid` pulse, with `echo_data` equal to that byte, exactly `2*BIT_CLKS` cycles after the clock edge that sampled `rx_valid`.
- R4: A strobe that arrives while an echo is still pending is ignored. It is not echoed and is not counted as a key byte.
- R5: Accepted byte number i (i = 0 for the first) is compared with `key_ref[8*i+7:8*i]`. `unlocked` rises only if all eight bytes match, and it rises in the same cycle as `done_pulse`.
- R6: A mismatch does not stop reception. All eight bytes are still accepted and echoed, `done_pulse` still fires, and the block stays locked.
- R7: `done_pulse` is high for exactly one cycle, coinciding with the eighth echo. After it, host strobes are ignored.
- R8: Once set, `unlocked` stays set through anything except a power-on reset. A power-on reset clears it.
- R9: After an ordinary reset (`rst_n` low with `por_n` high), `unlocked` keeps its value and no key entry takes place: no byte is echoed and `done_pulse` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous; clears everything, including the unlock flag |
| rst_n | input | 1 | Ordinary reset, active low, asynchronous; clears the sequencer and counters only |
| rx_valid | input | 1 | One-cycle strobe marking a byte received from the host |
| rx_data | input | BYTE_W | Byte received from the host |
| key_ref | input | KEY_BYTES*BYTE_W | Reference key; byte i occupies bits [8i+7:8i] |
| echo_valid | output | 1 | One-cycle request to send `echo_data` back to the host |
| echo_data | output | BYTE_W | Byte to be echoed |
| done_pulse | output | 1 | One-cycle pulse when the last key byte has been echoed |
| unlocked | output | 1 | Sticky flag that grants memory read and execute access |

## Verification
The bench builds the block with `BYTE_W=8` and `KEY_BYTES=8`, the default `SETTLE_CYCLES=4128`, and `BIT_CLKS=4`, which gives an echo delay of 8 cycles. With the full settle interval, one run holds three power-on entries plus the ordinary-reset cases. The short echo delay keeps each byte exchange near a dozen cycles. That leaves room to place an intruding strobe inside the pending-echo window and to time every echo against the cycle its byte was sampled.

// File: rtl/mkg_pkg.sv
package mkg_pkg;

   typedef enum logic [2:0] {
      GS_BOOT    = 3'd0,
      GS_SETTLE  = 3'd1,
      GS_COLLECT = 3'd2,
      GS_DONE    = 3'd3,
      GS_IDLE    = 3'd4
   } gate_state_t;

   // Counter width for a count range of n values, never below one bit.
   function automatic int unsigned cnt_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/mkg_settle_timer.sv
module mkg_settle_timer #(
   parameter int unsigned SETTLE_CYCLES = 4128
) (
   input  logic clk,
   input  logic arst_n,
   input  logic run,
   output logic expired
);
   import mkg_pkg::*;

   generate
      if (SETTLE_CYCLES == 0) begin : g_no_wait
         // No settle interval: the sequencer moves on at once.
         assign expired = run;
      end else begin : g_count
         localparam int unsigned W = cnt_width(SETTLE_CYCLES);
         localparam logic [W-1:0] LIMIT = W'(SETTLE_CYCLES - 1);

         logic [W-1:0] cnt;

         assign expired = run && (cnt == LIMIT);

         always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) begin
               cnt <= '0;
            end else if (run && !expired) begin
               cnt <= cnt + 1'b1;
            end
         end

         // The counter never passes the end of the settle window.
         p_settle_bounded_r2 : assert property (@(posedge clk) disable iff (!arst_n)
            (cnt == LIMIT) |=> (cnt == LIMIT) || (cnt == '0));
      end
   endgenerate

endmodule

// File: rtl/mkg_echo_delay.sv
module mkg_echo_delay #(
   parameter int unsigned BYTE_W     = 8,
   parameter int unsigned ECHO_DELAY = 8
) (
   input  logic              clk,
   input  logic              arst_n,
   input  logic              start,
   input  logic [BYTE_W-1:0] start_data,
   output logic              busy,
   output logic              fire,
   output logic              echo_valid,
   output logic [BYTE_W-1:0] echo_data
);
   import mkg_pkg::*;

   localparam int unsigned DW = cnt_width(ECHO_DELAY);
   localparam logic [DW-1:0] LAST = DW'(ECHO_DELAY - 1);

   logic [DW-1:0]     dly;
   logic [BYTE_W-1:0] held;

   assign fire = busy && (dly == LAST);

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         busy       <= 1'b0;
         dly        <= '0;
         held       <= '0;
         echo_valid <= 1'b0;
         echo_data  <= '0;
      end else begin
         echo_valid <= fire;
         if (fire) begin
            busy      <= 1'b0;
            echo_data <= held;
         end
         if (start) begin
            busy <= 1'b1;
            dly  <= '0;
            held <= start_data;
         end else if (busy && !fire) begin
            dly <= dly + 1'b1;
         end
      end
   end

   // An echo request lasts one cycle.
   p_echo_single_r3 : assert property (@(posedge clk) disable iff (!arst_n)
      echo_valid |=> !echo_valid);

   // A new byte is never taken while an echo is pending.
   p_start_when_free_r4 : assert property (@(posedge clk) disable iff (!arst_n)
      start |-> !busy);

endmodule

// File: rtl/mkg_key_check.sv
module mkg_key_check #(
   parameter int unsigned BYTE_W    = 8,
   parameter int unsigned KEY_BYTES = 8,
   parameter int unsigned IW        = 3
) (
   input  logic                        clk,
   input  logic                        por_n,
   input  logic                        sample,
   input  logic [IW-1:0]               idx,
   input  logic [BYTE_W-1:0]           rx_data,
   input  logic [KEY_BYTES*BYTE_W-1:0] key_ref,
   output logic                        any_miss
);

   logic [BYTE_W-1:0] key_arr [KEY_BYTES];
   logic [BYTE_W-1:0] ref_byte;

   generate
      for (genvar g = 0; g < KEY_BYTES; g++) begin : g_slice
         assign key_arr[g] = key_ref[g*BYTE_W +: BYTE_W];
      end
   endgenerate

   assign ref_byte = key_arr[idx];

   // The mismatch flag is sticky for the whole entry sequence. Only a
   // power-on reset starts a new entry, so only a power-on reset clears it.
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         any_miss <= 1'b0;
      end else if (sample && (rx_data != ref_byte)) begin
         any_miss <= 1'b1;
      end
   end

   p_miss_sticky_r6 : assert property (@(posedge clk) disable iff (!por_n)
      any_miss |=> any_miss);

endmodule

// File: rtl/monitor_key_gate.sv
module monitor_key_gate #(
   parameter int unsigned BYTE_W        = 8,
   parameter int unsigned KEY_BYTES     = 8,
   parameter int unsigned SETTLE_CYCLES = 4128,
   parameter int unsigned BIT_CLKS      = 4
) (
   input  logic                        clk,
   input  logic                        por_n,
   input  logic                        rst_n,
   input  logic                        rx_valid,
   input  logic [BYTE_W-1:0]           rx_data,
   input  logic [KEY_BYTES*BYTE_W-1:0] key_ref,
   output logic                        echo_valid,
   output logic [BYTE_W-1:0]           echo_data,
   output logic                        done_pulse,
   output logic                        unlocked
);
   import mkg_pkg::*;

   localparam int unsigned ECHO_DELAY = 2 * BIT_CLKS;
   localparam int unsigned IW         = cnt_width(KEY_BYTES);
   localparam logic [IW-1:0] LAST_IDX = IW'(KEY_BYTES - 1);

   generate
      if (BYTE_W < 1) begin : g_bad_width
         $error("BYTE_W must be at least 1");
      end
      if (KEY_BYTES < 1) begin : g_bad_keys
         $error("KEY_BYTES must be at least 1");
      end
      if (BIT_CLKS < 1) begin : g_bad_bit
         $error("BIT_CLKS must be at least 1");
      end
   endgenerate

   gate_state_t   state;
   logic [IW-1:0] idx;
   logic          entry_pending;
   logic          sys_rst_n;
   logic          settle_done;
   logic          accept;
   logic          busy;
   logic          fire;
   logic          any_miss;
   logic          last_fire;

   assign sys_rst_n = por_n & rst_n;
   assign accept    = (state == GS_COLLECT) && rx_valid && !busy;
   assign last_fire = (state == GS_COLLECT) && fire && (idx == LAST_IDX);

   // Set by a power-on reset. Cleared by any later ordinary reset, which
   // rules out key entry until the next power-on reset.
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         entry_pending <= 1'b1;
      end else if (!rst_n) begin
         entry_pending <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge sys_rst_n) begin
      if (!sys_rst_n) begin
         state      <= GS_BOOT;
         idx        <= '0;
         done_pulse <= 1'b0;
      end else begin
         done_pulse <= 1'b0;
         case (state)
            GS_BOOT:    state <= entry_pending ? GS_SETTLE : GS_IDLE;
            GS_SETTLE:  if (settle_done) state <= GS_COLLECT;
            GS_COLLECT: begin
               if (fire) begin
                  if (idx == LAST_IDX) begin
                     state      <= GS_DONE;
                     done_pulse <= 1'b1;
                  end else begin
                     idx <= idx + 1'b1;
                  end
               end
            end
            GS_DONE:    state <= GS_DONE;
            default:    state <= GS_IDLE;
         endcase
      end
   end

   // The unlock flag lives in the power-on domain alone.
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         unlocked <= 1'b0;
      end else if (last_fire && !any_miss) begin
         unlocked <= 1'b1;
      end
   end

   mkg_settle_timer #(
      .SETTLE_CYCLES(SETTLE_CYCLES)
   ) u_settle (
      .clk    (clk),
      .arst_n (sys_rst_n),
      .run    (state == GS_SETTLE),
      .expired(settle_done)
   );

   mkg_key_check #(
      .BYTE_W   (BYTE_W),
      .KEY_BYTES(KEY_BYTES),
      .IW       (IW)
   ) u_check (
      .clk     (clk),
      .por_n   (por_n),
      .sample  (accept),
      .idx     (idx),
      .rx_data (rx_data),
      .key_ref (key_ref),
      .any_miss(any_miss)
   );

   mkg_echo_delay #(
      .BYTE_W    (BYTE_W),
      .ECHO_DELAY(ECHO_DELAY)
   ) u_echo (
      .clk       (clk),
      .arst_n    (sys_rst_n),
      .start     (accept),
      .start_data(rx_data),
      .busy      (busy),
      .fire      (fire),
      .echo_valid(echo_valid),
      .echo_data (echo_data)
   );

   p_done_single_r7 : assert property (@(posedge clk) disable iff (!sys_rst_n)
      done_pulse |=> !done_pulse);

   p_done_with_echo_r7 : assert property (@(posedge clk) disable iff (!sys_rst_n)
      done_pulse |-> echo_valid);

   p_unlock_sticky_r8 : assert property (@(posedge clk) disable iff (!por_n)
      unlocked |=> unlocked);

   p_unlock_on_done_r5 : assert property (@(posedge clk) disable iff (!sys_rst_n)
      $rose(unlocked) |-> done_pulse);

   p_quiet_settle_r2 : assert property (@(posedge clk) disable iff (!sys_rst_n)
      (state == GS_SETTLE || state == GS_BOOT) |-> (!echo_valid && !busy));

   p_no_entry_idle_r9 : assert property (@(posedge clk) disable iff (!sys_rst_n)
      (state == GS_IDLE) |-> (!echo_valid && !done_pulse));

endmodule

// File: tb/monitor_key_gate_test.sv
`timescale 1ns/1ps
module monitor_key_gate_test;
   localparam int BYTE_W    = 8;
   localparam int KEY_BYTES = 8;
   localparam int SETTLE    = 4128;
   localparam int BIT_CLKS  = 4;
   localparam int DLY       = 2 * BIT_CLKS;

   logic                        clk = 1'b0;
   logic                        por_n, rst_n, rx_valid;
   logic [BYTE_W-1:0]           rx_data;
   logic [KEY_BYTES*BYTE_W-1:0] key_ref;
   logic                        echo_valid, done_pulse, unlocked;
   logic [BYTE_W-1:0]           echo_data;

   int    cyc = 0;
   int    checks = 0, errors = 0;
   int    echo_seen = 0, done_seen = 0;
   bit    finished = 0;
   string ign_tag = "R1";
   logic [BYTE_W-1:0] exp_q [$];
   int                expc_q [$];

   monitor_key_gate #(
      .BYTE_W(BYTE_W), .KEY_BYTES(KEY_BYTES),
      .SETTLE_CYCLES(SETTLE), .BIT_CLKS(BIT_CLKS)
   ) uut (
      .clk(clk), .por_n(por_n), .rst_n(rst_n), .rx_valid(rx_valid),
      .rx_data(rx_data), .key_ref(key_ref), .echo_valid(echo_valid),
      .echo_data(echo_data), .done_pulse(done_pulse), .unlocked(unlocked)
   );

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Monitor: every echo is popped from the scoreboard and compared.
   always @(negedge clk) begin
      if (echo_valid === 1'b1) begin
         echo_seen++;
         if (exp_q.size() == 0) begin
            check(0, ign_tag, "unexpected echo", int'(echo_data), -1);
         end else begin
            logic [BYTE_W-1:0] ed;
            int                ec;
            ed = exp_q.pop_front();
            ec = expc_q.pop_front();
            check(echo_data == ed, "R3", "echo data", int'(echo_data), int'(ed));
            check(cyc == ec, "R3", "echo cycle", cyc, ec);
         end
      end
      if (done_pulse === 1'b1) begin
         done_seen++;
         check(echo_valid === 1'b1, "R7", "done with last echo", int'(echo_valid), 1);
      end
   end

   function automatic logic [BYTE_W-1:0] kb(input int i);
      return key_ref[i*BYTE_W +: BYTE_W];
   endfunction

   task automatic send(input logic [BYTE_W-1:0] b, input bit expect_echo);
      @(negedge clk);
      rx_valid = 1'b1;
      rx_data  = b;
      if (expect_echo) begin
         exp_q.push_back(b);
         expc_q.push_back(cyc + 1 + DLY);
      end
      @(negedge clk);
      rx_valid = 1'b0;
      repeat (DLY + BIT_CLKS) @(negedge clk);
   endtask

   task automatic power_on();
      @(negedge clk);
      por_n = 1'b0;
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(unlocked == 1'b0, "R1", "unlocked in POR", int'(unlocked), 0);
      check(echo_valid == 1'b0 && done_pulse == 1'b0, "R1", "outputs quiet in POR",
            int'(echo_valid | done_pulse), 0);
      por_n = 1'b1;
   endtask

   task automatic plain_reset(input logic exp_unl);
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check(unlocked == exp_unl, "R9", "unlocked held in reset", int'(unlocked), int'(exp_unl));
      rst_n = 1'b1;
   endtask

   task automatic run_key(input int bad_pos);
      for (int i = 0; i < KEY_BYTES; i++) begin
         send((i == bad_pos) ? (kb(i) ^ 8'h80) : kb(i), 1'b1);
      end
   endtask

   initial begin
      int e0, d0;
      por_n = 1'b0; rst_n = 1'b0; rx_valid = 1'b0; rx_data = '0;
      for (int i = 0; i < KEY_BYTES; i++) key_ref[i*BYTE_W +: BYTE_W] = 8'(8'hA5 ^ (i * 59));

      // Phase 1: power-on, early byte, correct key with an intruding strobe
      power_on();
      ign_tag = "R2";
      repeat (40) @(negedge clk);
      e0 = echo_seen;
      send(kb(0), 1'b0);
      check(echo_seen == e0, "R2", "byte during settle echoed", echo_seen - e0, 0);
      repeat (SETTLE) @(negedge clk);
      ign_tag = "R4";
      d0 = done_seen;
      @(negedge clk);
      rx_valid = 1'b1; rx_data = kb(0);
      exp_q.push_back(kb(0)); expc_q.push_back(cyc + 1 + DLY);
      @(negedge clk); rx_valid = 1'b0;
      @(negedge clk); rx_valid = 1'b1; rx_data = 8'h00;
      @(negedge clk); rx_valid = 1'b0;
      repeat (DLY + BIT_CLKS) @(negedge clk);
      for (int i = 1; i < KEY_BYTES; i++) send(kb(i), 1'b1);
      check(exp_q.size() == 0, "R3", "echoes outstanding", exp_q.size(), 0);
      check(done_seen - d0 == 1, "R7", "done pulses", done_seen - d0, 1);
      check(unlocked == 1'b1, "R5", "unlock on matching key", int'(unlocked), 1);
      check(unlocked == 1'b1, "R4", "intruding strobe ignored", int'(unlocked), 1);

      // Phase 2: byte after done is ignored
      ign_tag = "R7";
      e0 = echo_seen;
      send(8'h3C, 1'b0);
      check(echo_seen == e0, "R7", "echo after done", echo_seen - e0, 0);
      check(unlocked == 1'b1, "R8", "unlocked kept after done", int'(unlocked), 1);

      // Phase 3: ordinary reset keeps unlock, no entry
      plain_reset(1'b1);
      ign_tag = "R9";
      e0 = echo_seen; d0 = done_seen;
      send(kb(0), 1'b0);
      repeat (SETTLE + 20) @(negedge clk);
      send(kb(0), 1'b0);
      check(echo_seen == e0, "R9", "echo after ordinary reset", echo_seen - e0, 0);
      check(done_seen == d0, "R9", "done after ordinary reset", done_seen - d0, 0);
      check(unlocked == 1'b1, "R8", "unlock survives ordinary reset", int'(unlocked), 1);

      // Phase 4: power-on clears; mismatch in byte 3 still runs all eight
      power_on();
      check(unlocked == 1'b0, "R8", "POR clears unlock", int'(unlocked), 0);
      ign_tag = "R2";
      repeat (SETTLE + 5) @(negedge clk);
      ign_tag = "R6";
      e0 = echo_seen; d0 = done_seen;
      run_key(3);
      check(echo_seen - e0 == KEY_BYTES, "R6", "echoes after mismatch", echo_seen - e0, KEY_BYTES);
      check(done_seen - d0 == 1, "R6", "done after mismatch", done_seen - d0, 1);
      check(unlocked == 1'b0, "R6", "locked after mismatch", int'(unlocked), 0);

      // Phase 5: only the last byte wrong
      power_on();
      ign_tag = "R2";
      repeat (SETTLE + 5) @(negedge clk);
      ign_tag = "R5";
      run_key(KEY_BYTES - 1);
      check(exp_q.size() == 0, "R3", "echoes outstanding", exp_q.size(), 0);
      check(unlocked == 1'b0, "R5", "locked on last-byte mismatch", int'(unlocked), 0);

      // Phase 6: ordinary reset while locked
      plain_reset(1'b0);
      ign_tag = "R9";
      repeat (20) @(negedge clk);
      e0 = echo_seen;
      send(kb(0), 1'b0);
      check(echo_seen == e0, "R9", "echo while locked after reset", echo_seen - e0, 0);
      check(unlocked == 1'b0, "R9", "still locked", int'(unlocked), 0);

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         check(0, "WATCHDOG", "run timed out", cyc, 0);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule